// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the time of day and the calendar date as packed BCD digits and moves them forward by one second on every cycle in which a one-second enable pulse is present. Seconds roll into minutes, minutes into hours, and the hour rollover moves the date. The date holds a day, a month, a two-digit year and a weekday number. Month lengths follow the usual calendar, and February gets its extra day in leap years with no help from software.

The clock can count in 24-hour mode or in 12-hour mode with a PM flag. Two single-cycle commands move the hour forward or back by one, for seasonal clock changes. Software loads a new time, a new date or a new hour format by raising an initialization request, waiting for the ready flag, and writing. While the ready flag is high the counters hold still. The two packed words are always available for readout.

Top module: `calendar_clock`

## Requirements
- R1: After reset the time word is 0x00000000 (00:00:00, 24-hour mode), the date word is 0x00002101 (day 01, month 01, weekday 1, year 00), and initReady and mode12 are 0.
- R2: Time word fields: seconds units [3:0], seconds tens [6:4], minutes units [11:8], minutes tens [14:12], hours units [19:16], hours tens [21:20], PM flag [22]. Bits 7, 15 and 31:23 always read 0. A load takes these positions from timeData.
- R3: Date word fields: day units [3:0], day tens [5:4], month units [11:8], month tens [12], weekday [15:13], year units [19:16], year tens [23:20]. Bits 7:6 and 31:24 always read 0. A load takes these positions from dateData.
- R4: initReady follows initReq one cycle later. timeWr, dateWr and fmtWr take effect only in a cycle where initReady is 1 and are ignored otherwise.
- R5: Each secTick advances the time by one second with BCD carry from seconds into minutes and from minutes into hours. secTick is ignored while initReady is 1.
- R6: In 24-hour mode (mode12 = 0) 23:59:59 advances to 00:00:00 and the date moves one day forward on the same edge.
- R7: In 12-hour mode (mode12 = 1, written through fmtData) hours run 12, 01 … 11. PM toggles on the 11→12 step. The date moves forward when 11:59:59 PM becomes 12:00:00 AM. In 24-hour mode the PM bit reads 0.
- R8: The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for 04, 06, 09 and 11. For 02 it is 29 when the year value is divisible by 4 (00 included) and 28 otherwise. After the last day comes day 01 of the next month. Month 12 rolls to 01 and the year goes up by one, with 99 wrapping to 00.
- R9: The weekday goes up by one on every date advance and wraps from 7 to 1.
- R10: hourAddCmd moves the hour forward by one and leaves minutes and seconds alone. It uses the same rollover as normal counting, so 23→00 and 11 PM→12 AM also advance the date.
- R11: hourSubCmd moves the hour back by one (12 PM→11 AM, 01→12 in 12-hour mode). At hour 00 in 24-hour mode and at 12 AM it is ignored.
- R12: An hour command is ignored when secTick is present in the same cycle, when both commands are present together, or while initReady is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| secTick | input | 1 | One-second advance enable |
| initReq | input | 1 | Initialization mode request, held by software |
| timeWr | input | 1 | Load timeData into the time counters |
| timeData | input | 32 | Packed time word to load |
| dateWr | input | 1 | Load dateData into the date counters |
| dateData | input | 32 | Packed date word to load |
| fmtWr | input | 1 | Write the hour format |
| fmtData | input | 1 | Hour format: 1 = 12-hour, 0 = 24-hour |
| hourAddCmd | input | 1 | Move the hour forward by one |
| hourSubCmd | input | 1 | Move the hour back by one |
| initReady | output | 1 | Initialization mode active; loads allowed, counting stopped |
| mode12 | output | 1 | Current hour format |
| timeWord | output | 32 | Packed BCD time of day |
| dateWord | output | 32 | Packed BCD date |

## Verification
Every counter feeds a register that drives the output words directly. A wrong carry, a wrong hour step or a missed PM toggle therefore shows in timeWord on the first edge after the tick or command that triggers it. A wrong month length or leap-year decision stays hidden until a day advance happens on the last day of that month, and a wrong weekday shows only at a rollover. The directed scenarios place the clock one tick before each such boundary. A loss of the init gating shows as a word that changes during a cycle in which it should hold still.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

  localparam int SEC_W  = 7;  // seconds tens (3) + units (4)
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;  // hour tens (2) + units (4)
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;
  localparam int WD_W   = 3;

  // strobes from control to the datapaths
  typedef struct packed {
    logic loadTime;
    logic loadDate;
    logic secStep;
    logic hourUp;
    logic hourDown;
  } cal_strobe_t;

  // BCD pair plus one, no wrap
  function automatic logic [7:0] bcdStep(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // BCD pair minus one, no wrap
  function automatic logic [7:0] bcdBack(input logic [7:0] v);
    if (v[3:0] == 4'h0) return {v[7:4] - 4'h1, 4'h9};
    return {v[7:4], v[3:0] - 4'h1};
  endfunction

  // a BCD year is divisible by four when units[1:0] equals {tens[0],0}
  function automatic logic isLeap(input logic [7:0] year);
    return year[1:0] == {year[4], 1'b0};
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] month, input logic [7:0] year);
    case (month)
      8'h02:                      return isLeap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        initReq,
  input  logic        timeWr,
  input  logic        dateWr,
  input  logic        fmtWr,
  input  logic        fmtData,
  input  logic        hourAddCmd,
  input  logic        hourSubCmd,
  output logic        initReady,
  output logic        mode12,
  output cal_strobe_t strobe
);

  logic cmdOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReady <= 1'b0;
      mode12    <= 1'b0;
    end else begin
      initReady <= initReq;
      if (initReady && fmtWr) mode12 <= fmtData;
    end
  end

  // hour commands only in free-running mode, never beside a tick, never both
  assign cmdOk = !initReady && !secTick && (hourAddCmd ^ hourSubCmd);

  always_comb begin
    strobe.loadTime = initReady && timeWr;
    strobe.loadDate = initReady && dateWr;
    strobe.secStep  = !initReady && secTick;
    strobe.hourUp   = cmdOk && hourAddCmd;
    strobe.hourDown = cmdOk && hourSubCmd;
  end

endmodule

// File: rtl/calendar_time.sv
module calendar_time
  import calendar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cal_strobe_t strobe,
  input  logic        mode12,
  input  logic [31:0] timeData,
  output logic [31:0] timeWord,
  output logic        dayCarry
);

  logic [SEC_W-1:0]  sec,  secN;
  logic [MIN_W-1:0]  min,  minN;
  logic [HOUR_W-1:0] hour, hourN;
  logic              pm,   pmN;
  logic              hourUpNow;
  logic [7:0]        hr8;
  logic              unusedBits;

  assign unusedBits = ^{timeData[31:23], timeData[15], timeData[7]};
  assign hr8 = 8'(hour);

  always_comb begin
    secN      = sec;
    minN      = min;
    hourN     = hour;
    pmN       = pm;
    dayCarry  = 1'b0;
    hourUpNow = strobe.hourUp;
    if (strobe.loadTime) begin
      secN  = timeData[6:0];
      minN  = timeData[14:8];
      hourN = timeData[21:16];
      pmN   = timeData[22];
    end else begin
      if (strobe.secStep) begin
        if (sec == 7'h59) begin
          secN = '0;
          if (min == 7'h59) begin
            minN      = '0;
            hourUpNow = 1'b1;
          end else begin
            minN = 7'(bcdStep(8'(min)));
          end
        end else begin
          secN = 7'(bcdStep(8'(sec)));
        end
      end
      if (hourUpNow) begin
        if (mode12) begin
          if (hr8 == 8'h11) begin
            hourN    = 6'h12;
            pmN      = !pm;
            dayCarry = pm;
          end else if (hr8 == 8'h12) begin
            hourN = 6'h01;
          end else begin
            hourN = 6'(bcdStep(hr8));
          end
        end else begin
          if (hr8 == 8'h23) begin
            hourN    = '0;
            dayCarry = 1'b1;
          end else begin
            hourN = 6'(bcdStep(hr8));
          end
        end
      end
      if (strobe.hourDown) begin
        if (mode12) begin
          if (hr8 == 8'h12) begin
            if (pm) begin
              hourN = 6'h11;
              pmN   = 1'b0;
            end
          end else if (hr8 == 8'h01) begin
            hourN = 6'h12;
          end else begin
            hourN = 6'(bcdBack(hr8));
          end
        end else if (hr8 != 8'h00) begin
          hourN = 6'(bcdBack(hr8));
        end
      end
    end
    if (!mode12) pmN = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
      pm   <= 1'b0;
    end else begin
      sec  <= secN;
      min  <= minN;
      hour <= hourN;
      pm   <= pmN;
    end
  end

  assign timeWord = {9'b0, pm, hour, 1'b0, min, 1'b0, sec};

endmodule

// File: rtl/calendar_date.sv
module calendar_date
  import calendar_pkg::*;
#(
  parameter int WEEK_LEN = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  cal_strobe_t strobe,
  input  logic        dayStep,
  input  logic [31:0] dateData,
  output logic [31:0] dateWord
);

  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WEEK_LEN);

  logic [DAY_W-1:0]  day,   dayN;
  logic [MON_W-1:0]  month, monthN;
  logic [YEAR_W-1:0] year,  yearN;
  logic [WD_W-1:0]   wday,  wdayN;
  logic              unusedBits;

  assign unusedBits = ^{dateData[31:24], dateData[7:6]};

  always_comb begin
    dayN   = day;
    monthN = month;
    yearN  = year;
    wdayN  = wday;
    if (strobe.loadDate) begin
      dayN   = dateData[5:0];
      monthN = dateData[12:8];
      wdayN  = dateData[15:13];
      yearN  = dateData[23:16];
    end else if (dayStep) begin
      wdayN = (wday == WD_LAST) ? WD_W'(1) : wday + WD_W'(1);
      if (8'(day) == lastDay(8'(month), year)) begin
        dayN = 6'h01;
        if (month == 5'h12) begin
          monthN = 5'h01;
          yearN  = (year == 8'h99) ? 8'h00 : bcdStep(year);
        end else begin
          monthN = 5'(bcdStep(8'(month)));
        end
      end else begin
        dayN = 6'(bcdStep(8'(day)));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      day   <= 6'h01;
      month <= 5'h01;
      year  <= 8'h00;
      wday  <= WD_W'(1);
    end else begin
      day   <= dayN;
      month <= monthN;
      year  <= yearN;
      wday  <= wdayN;
    end
  end

  assign dateWord = {8'b0, year, wday, month, 2'b0, day};

endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import calendar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        initReq,
  input  logic        timeWr,
  input  logic [31:0] timeData,
  input  logic        dateWr,
  input  logic [31:0] dateData,
  input  logic        fmtWr,
  input  logic        fmtData,
  input  logic        hourAddCmd,
  input  logic        hourSubCmd,
  output logic        initReady,
  output logic        mode12,
  output logic [31:0] timeWord,
  output logic [31:0] dateWord
);

  cal_strobe_t strobe;
  logic        dayCarry;

  calendar_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .initReq(initReq),
    .timeWr(timeWr), .dateWr(dateWr), .fmtWr(fmtWr), .fmtData(fmtData),
    .hourAddCmd(hourAddCmd), .hourSubCmd(hourSubCmd),
    .initReady(initReady), .mode12(mode12), .strobe(strobe)
  );

  calendar_time i_time (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode12(mode12),
    .timeData(timeData), .timeWord(timeWord), .dayCarry(dayCarry)
  );

  calendar_date #(.WEEK_LEN(7)) i_date (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dayStep(dayCarry),
    .dateData(dateData), .dateWord(dateWord)
  );

endmodule

// File: rtl/calendar_checker.sv
module calendar_checker (
  input logic        clk,
  input logic        rstN,
  input logic        secTick,
  input logic        initReq,
  input logic        timeWr,
  input logic        dateWr,
  input logic        fmtWr,
  input logic        hourAddCmd,
  input logic        hourSubCmd,
  input logic        initReady,
  input logic        mode12,
  input logic [31:0] timeWord,
  input logic [31:0] dateWord
);

  assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> initReady);

  assert_ready_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !initReq |=> !initReady);

  assert_time_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (initReady && !timeWr && !fmtWr) |=> $stable(timeWord));

  assert_date_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (initReady && !dateWr) |=> $stable(dateWord));

  assert_time_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !hourAddCmd && !hourSubCmd && !timeWr && !fmtWr) |=> $stable(timeWord));

  assert_date_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!initReady && !secTick && !hourAddCmd) |=> $stable(dateWord));

  assert_time_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (timeWord[31:23] == 9'd0) && !timeWord[15] && !timeWord[7]);

  assert_date_reserved_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dateWord[31:24] == 8'd0) && (dateWord[7:6] == 2'd0));

  assert_no_pm_24h_R7: assert property (@(posedge clk) disable iff (!rstN)
    !mode12 |=> !timeWord[22]);

  assert_no_sub_on_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && hourSubCmd && !initReady && timeWord[7:0] != 8'h59)
      |=> (timeWord[31:8] == $past(timeWord[31:8])));

endmodule

bind calendar_clock calendar_checker i_checker (.*);

// File: tb/test_calendar_clock.sv
module test_calendar_clock;

  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 0, initReq = 0, timeWr = 0, dateWr = 0;
  logic        fmtWr = 0, fmtData = 0, hourAddCmd = 0, hourSubCmd = 0;
  logic [31:0] timeData = '0, dateData = '0;
  logic        initReady, mode12;
  logic [31:0] timeWord, dateWord;

  int checks = 0;
  int fails  = 0;

  always #(CYC/2) clk = ~clk;

  calendar_clock i_calendar_clock (
    .clk(clk), .rstN(rstN), .secTick(secTick), .initReq(initReq),
    .timeWr(timeWr), .timeData(timeData), .dateWr(dateWr), .dateData(dateData),
    .fmtWr(fmtWr), .fmtData(fmtData), .hourAddCmd(hourAddCmd), .hourSubCmd(hourSubCmd),
    .initReady(initReady), .mode12(mode12), .timeWord(timeWord), .dateWord(dateWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic enterInit();
    initReq = 1'b1;
    @(negedge clk);
  endtask

  task automatic leaveInit();
    initReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic loadAll(input logic [31:0] t, input logic [31:0] d);
    enterInit();
    timeWr = 1'b1; timeData = t; dateWr = 1'b1; dateData = d;
    @(negedge clk);
    timeWr = 1'b0; dateWr = 1'b0;
    leaveInit();
  endtask

  task automatic loadTime(input logic [31:0] t);
    enterInit();
    timeWr = 1'b1; timeData = t;
    @(negedge clk);
    timeWr = 1'b0;
    leaveInit();
  endtask

  task automatic setFormat(input logic f);
    enterInit();
    fmtWr = 1'b1; fmtData = f;
    @(negedge clk);
    fmtWr = 1'b0;
    leaveInit();
  endtask

  task automatic tick();
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic command(input logic add, input logic sub, input logic withTick);
    hourAddCmd = add; hourSubCmd = sub; secTick = withTick;
    @(negedge clk);
    hourAddCmd = 1'b0; hourSubCmd = 1'b0; secTick = 1'b0;
  endtask

  task automatic testReset();
    check("R1 time", timeWord, 32'h0000_0000);
    check("R1 date", dateWord, 32'h0000_2101);
    check("R1 flags", {30'd0, initReady, mode12}, 32'd0);
  endtask

  task automatic testInitGating();
    timeWr = 1'b1; timeData = 32'h0012_3456; fmtWr = 1'b1; fmtData = 1'b1;
    @(negedge clk);
    timeWr = 1'b0; fmtWr = 1'b0;
    check("R4 time load outside init", timeWord, 32'h0);
    check("R4 format outside init", {31'd0, mode12}, 32'd0);
    enterInit();
    check("R4 ready after request", {31'd0, initReady}, 32'd1);
    timeWr = 1'b1; timeData = 32'h0023_5958;
    @(negedge clk);
    timeWr = 1'b0;
    tick();
    check("R5 tick frozen in init", timeWord, 32'h0023_5958);
    command(1'b1, 1'b0, 1'b0);
    check("R12 add ignored in init", timeWord, 32'h0023_5958);
    leaveInit();
    check("R4 ready drops", {31'd0, initReady}, 32'd0);
  endtask

  task automatic testLayout();
    loadAll(32'hFF80_8080 | 32'h0012_3456, 32'hFF00_00C0 | 32'h0099_5231);
    check("R2 time layout", timeWord, 32'h0012_3456);
    check("R3 date layout", dateWord, 32'h0099_5231);
    loadTime(32'h0052_3000);
    check("R7 no PM in 24h", timeWord, 32'h0012_3000);
  endtask

  task automatic testCounting();
    loadTime(32'h0009_5959);
    tick();
    check("R5 carry to hour", timeWord, 32'h0010_0000);
    tick();
    check("R5 single second", timeWord, 32'h0010_0001);
    loadAll(32'h0023_5958, 32'h0023_E228);
    tick();
    check("R5 step", timeWord, 32'h0023_5959);
    tick();
    check("R6 midnight time", timeWord, 32'h0000_0000);
    check("R8 R9 Feb28 non-leap, wd 7->1", dateWord, 32'h0023_2301);
  endtask

  task automatic testCalendar();
    loadAll(32'h0023_5959, 32'h0024_6228);
    tick();
    check("R8 leap Feb29", dateWord, 32'h0024_8229);
    loadTime(32'h0023_5959);
    tick();
    check("R8 leap Mar1", dateWord, 32'h0024_A301);
    loadAll(32'h0023_5959, 32'h0099_5231);
    tick();
    check("R8 year wrap", dateWord, 32'h0000_6101);
    loadAll(32'h0023_5959, 32'h0001_2430);
    tick();
    check("R8 30-day month", dateWord, 32'h0001_4501);
    loadAll(32'h0023_5959, 32'h0000_4228);
    tick();
    check("R8 year 00 leap", dateWord, 32'h0000_6229);
  endtask

  task automatic testTwelveHour();
    setFormat(1'b1);
    check("R7 format set", {31'd0, mode12}, 32'd1);
    loadAll(32'h0011_5959, 32'h0001_2430);
    tick();
    check("R7 11AM->12PM", timeWord, 32'h0052_0000);
    check("R7 no date at noon", dateWord, 32'h0001_2430);
    loadTime(32'h0052_5959);
    tick();
    check("R7 12PM->1PM", timeWord, 32'h0041_0000);
    loadTime(32'h0051_5959);
    tick();
    check("R7 11PM->12AM", timeWord, 32'h0012_0000);
    check("R7 date at 12AM", dateWord, 32'h0001_4501);
  endtask

  task automatic testHourCommands12();
    command(1'b0, 1'b1, 1'b0);
    check("R11 sub at 12AM ignored", timeWord, 32'h0012_0000);
    command(1'b1, 1'b0, 1'b0);
    check("R10 add 12AM->1AM", timeWord, 32'h0001_0000);
    command(1'b0, 1'b1, 1'b0);
    check("R11 sub 1AM->12AM", timeWord, 32'h0012_0000);
    loadTime(32'h0052_3000);
    command(1'b0, 1'b1, 1'b0);
    check("R11 sub 12PM->11AM", timeWord, 32'h0011_3000);
  endtask

  task automatic testHourCommands24();
    setFormat(1'b0);
    check("R7 PM cleared in 24h", timeWord, 32'h0011_3000);
    loadAll(32'h0000_0000, 32'h0023_E228);
    command(1'b0, 1'b1, 1'b0);
    check("R11 sub at 00 ignored", timeWord, 32'h0000_0000);
    check("R11 date kept", dateWord, 32'h0023_E228);
    loadTime(32'h0023_1500);
    command(1'b1, 1'b0, 1'b0);
    check("R10 add 23->00", timeWord, 32'h0000_1500);
    check("R10 add advances date", dateWord, 32'h0023_2301);
    loadTime(32'h0010_1010);
    command(1'b0, 1'b1, 1'b0);
    check("R11 sub 10->09", timeWord, 32'h0009_1010);
    command(1'b1, 1'b0, 1'b0);
    check("R10 add 09->10", timeWord, 32'h0010_1010);
  endtask

  task automatic testConflicts();
    command(1'b1, 1'b0, 1'b1);
    check("R12 add with tick", timeWord, 32'h0010_1011);
    command(1'b1, 1'b1, 1'b0);
    check("R12 add and sub", timeWord, 32'h0010_1011);
    command(1'b0, 1'b1, 1'b1);
    check("R12 sub with tick", timeWord, 32'h0010_1012);
  endtask

  initial begin
    #(CYC * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInitGating();
    testLayout();
    testCounting();
    testCalendar();
    testTwelveHour();
    testHourCommands12();
    testHourCommands24();
    testConflicts();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule